// File: doc/BRIEF.md
# Hex-ASCII Nibble UART Transmitter

This block drains a queue of captured 4-bit symbols and sends each one as a readable character on a serial line. A plain symbol becomes one uppercase hexadecimal digit. Two marker flags stored beside the symbol replace it with a control character: the end-of-record flag becomes a newline, and the aborted-record flag becomes an exclamation mark.

The block runs directly on a 2.5 MHz bit clock, so one clock is one bit time. The line rate is therefore fixed at 2,500,000 baud and no divider is needed. Each character goes out as an 8N1 frame that is exactly ten clocks long. The source queue is a show-ahead FIFO. Its head entry is visible whenever it is not empty, and the block takes an entry by pulsing the read strobe for one clock. If the queue stays non-empty, frames follow one another with no idle time between them.

Top module: `hexNibbleUartTx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `txd` is high.
- R2: `fifoRead` is never high while `fifoEmpty` is high.
- R3: Each frame starts with a low start bit in the clock that follows the `fifoRead` clock. Eight data bits follow, least significant first, and then one high stop bit. Every bit lasts exactly one clock.
- R4: If both flags are clear, a symbol value from 0 to 9 is sent as 0x30 plus that value (the characters '0' to '9').
- R5: If both flags are clear, a symbol value from 10 to 15 is sent as 0x37 plus that value (the characters 'A' to 'F').
- R6: If `fifoEnd` is set and `fifoAbort` is clear, the character 0x0A (newline) is sent, whatever the symbol value.
- R7: If `fifoAbort` is set, the character 0x21 ('!') is sent, whatever the symbol value and whatever `fifoEnd` is.
- R8: While the queue stays non-empty, consecutive frames start exactly 10 clocks apart, so the line has no idle bit between them.
- R9: An entry that arrives while a frame is in progress is not read before that frame's stop bit. Its start bit follows that stop bit directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.5 MHz bit clock; one bit time per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEmpty | input | 1 | Source queue has no entry |
| fifoNibble | input | 4 | Symbol value of the head entry |
| fifoEnd | input | 1 | Head entry marks the end of a record |
| fifoAbort | input | 1 | Head entry marks an aborted record |
| fifoRead | output | 1 | Pops the head entry at this clock edge |
| txd | output | 1 | Serial line output; idles high |

## Verification
Suppose the bit counter ends on the wrong value or the active flag gets out of step. The next `fifoRead` then comes too early or too late, and a frame shows up shorter or longer than ten clocks. The received character is corrupted, and the spacing between start bits is no longer 10. Both show up within the affected frame or the one after it. A fault in the encoder or the shift register shows up in the very next frame, as a wrong character or a low stop bit. The bench therefore decodes every frame at the line and compares it with a queue of expected characters. It also measures the distance between start bits in back-to-back and mid-frame arrival cases.

// File: rtl/hexUartPkg.sv
package hexUartPkg;

  localparam int NIB_W  = 4;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic load;   // capture head entry, drive start bit
    logic shift;  // advance to the next bit of the frame
  } txStrobe_t;

  localparam logic [CHAR_W-1:0] CH_NEWLINE = 8'h0A;
  localparam logic [CHAR_W-1:0] CH_BANG    = 8'h21;
  localparam logic [CHAR_W-1:0] CH_ZERO    = 8'h30;
  localparam logic [CHAR_W-1:0] CH_ALPHA   = 8'h37;  // 'A' minus ten

  function automatic logic [CHAR_W-1:0] encodeSymbol(
    input logic [NIB_W-1:0] nib,
    input logic             endMark,
    input logic             abortMark
  );
    logic [CHAR_W-1:0] ch;
    if (abortMark)       ch = CH_BANG;
    else if (endMark)    ch = CH_NEWLINE;
    else if (nib < 4'd10) ch = CH_ZERO + CHAR_W'(nib);
    else                 ch = CH_ALPHA + CHAR_W'(nib);
    return ch;
  endfunction

endpackage

// File: rtl/hexUartCtrl.sv
module hexUartCtrl
  import hexUartPkg::*;
#(
  parameter int FRAME_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEmpty,
  output logic       fifoRead,
  output txStrobe_t  strobe,
  output logic       frameActive
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             active;
  logic             lastBit;

  assign lastBit     = active && (bitCnt == LAST_BIT);
  assign fifoRead    = !fifoEmpty && (!active || lastBit);
  assign frameActive = active;

  always_comb begin
    strobe       = '0;
    strobe.load  = fifoRead;
    strobe.shift = active && !lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (strobe.load) begin
      active <= 1'b1;
      bitCnt <= '0;
    end else if (lastBit) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (active) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/hexUartDatapath.sv
module hexUartDatapath
  import hexUartPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  logic [NIB_W-1:0] fifoNibble,
  input  logic             fifoEnd,
  input  logic             fifoAbort,
  output logic             txd
);

  // data bits plus the trailing stop bit
  logic [CHAR_W:0]   shReg;
  logic              txdQ;
  logic [CHAR_W-1:0] nextChar;

  assign nextChar = encodeSymbol(fifoNibble, fifoEnd, fifoAbort);
  assign txd      = txdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '1;
      txdQ  <= 1'b1;
    end else if (strobe.load) begin
      shReg <= {1'b1, nextChar};
      txdQ  <= 1'b0;
    end else if (strobe.shift) begin
      txdQ  <= shReg[0];
      shReg <= {1'b1, shReg[CHAR_W:1]};
    end
  end

endmodule

// File: rtl/hexNibbleUartTx.sv
module hexNibbleUartTx
  import hexUartPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  logic [NIB_W-1:0] fifoNibble,
  input  logic             fifoEnd,
  input  logic             fifoAbort,
  output logic             fifoRead,
  output logic             txd
);

  localparam int FRAME_BITS = CHAR_W + 2;

  txStrobe_t strobe;
  logic      frameActive;

  hexUartCtrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fifoEmpty   (fifoEmpty),
    .fifoRead    (fifoRead),
    .strobe      (strobe),
    .frameActive (frameActive)
  );

  hexUartDatapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fifoNibble (fifoNibble),
    .fifoEnd    (fifoEnd),
    .fifoAbort  (fifoAbort),
    .txd        (txd)
  );

endmodule

// File: rtl/hexUartChecks.sv
module hexUartChecks #(
  parameter int FRAME_BITS = 10
) (
  input logic clk,
  input logic rstN,
  input logic fifoEmpty,
  input logic fifoRead,
  input logic txd,
  input logic frameActive
);

  localparam int SR_W = $clog2(FRAME_BITS + 2) + 1;
  localparam logic [SR_W-1:0] SR_MAX = '1;

  // clocks elapsed since the most recent read; 0 means none yet
  logic [SR_W-1:0] sinceRead;

  always_ff @(posedge clk) begin
    if (!rstN)                                    sinceRead <= '0;
    else if (fifoRead)                            sinceRead <= SR_W'(1);
    else if (sinceRead != '0 && sinceRead != SR_MAX) sinceRead <= sinceRead + 1'b1;
  end

  p_read_nonempty_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |-> !fifoEmpty);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> txd);

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |=> !txd);

  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRead == SR_W'(FRAME_BITS)) |-> txd);

  p_no_early_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRead && sinceRead != '0) |-> (sinceRead >= SR_W'(FRAME_BITS)));

endmodule

bind hexNibbleUartTx hexUartChecks #(.FRAME_BITS(hexUartPkg::CHAR_W + 2)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .fifoEmpty   (fifoEmpty),
  .fifoRead    (fifoRead),
  .txd         (txd),
  .frameActive (frameActive)
);

// File: tb/sim_hexNibbleUartTx.sv
`timescale 1ns/1ps
module sim_hexNibbleUartTx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEmpty;
  logic [3:0] fifoNibble;
  logic       fifoEnd, fifoAbort;
  logic       fifoRead, txd;

  always #10 clk = ~clk;

  hexNibbleUartTx u0 (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoNibble(fifoNibble),
    .fifoEnd(fifoEnd), .fifoAbort(fifoAbort), .fifoRead(fifoRead), .txd(txd)
  );

  // behavioural show-ahead FIFO
  logic [5:0] fifoMem [0:255];
  int wrPtr = 0;
  int rdPtr = 0;
  assign fifoEmpty  = (rdPtr == wrPtr);
  assign fifoNibble = fifoMem[rdPtr[7:0]][3:0];
  assign fifoEnd    = fifoMem[rdPtr[7:0]][4];
  assign fifoAbort  = fifoMem[rdPtr[7:0]][5];
  always @(posedge clk) if (fifoRead) rdPtr <= rdPtr + 1;

  int errors = 0;
  int checks = 0;
  logic [7:0] expQ [$];
  int startCyc [$];
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expectChar(input logic [3:0] n, input logic e, input logic a);
    if (a) return 8'h21;               // R7
    if (e) return 8'h0A;               // R6
    if (n <= 4'd9) return 8'h30 + {4'h0, n}; // R4
    return 8'h37 + {4'h0, n};          // R5
  endfunction

  // driver: enqueue into FIFO and scoreboard
  task automatic pushItem(input logic [3:0] n, input logic e, input logic a);
    fifoMem[wrPtr[7:0]] = {a, e, n};
    expQ.push_back(expectChar(n, e, a));
    wrPtr = wrPtr + 1;
  endtask

  // monitor: decode frames at mid-bit (negedge)
  int rxBit = -1;
  logic [7:0] rxData;
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (fifoRead && fifoEmpty) chk(1'b0, "R2 read while empty", 1, 0);
      if (rxBit < 0) begin
        if (txd == 1'b0) begin
          rxBit = 0;
          startCyc.push_back(cyc);
        end
      end else if (rxBit < 8) begin
        rxData[rxBit] = txd;
        rxBit++;
      end else begin
        chk(txd == 1'b1, "R3 stop bit", int'(txd), 1);
        if (expQ.size() == 0) chk(1'b0, "R3 unexpected frame", int'(rxData), 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk(rxData == e, "R3/R4/R5/R6/R7 character", int'(rxData), int'(e));
        end
        rxBit = -1;
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  task automatic waitDrain();
    while (expQ.size() != 0 || !fifoEmpty || rxBit >= 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkSpacing(input int first, input int cnt, input string req);
    for (int i = first + 1; i < first + cnt; i++)
      chk(startCyc[i] - startCyc[i-1] == 10, req, startCyc[i] - startCyc[i-1], 10);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset line high", int'(txd), 1);
    chk(fifoRead == 1'b0, "R2 no read when empty", int'(fifoRead), 0);
    repeat (20) @(negedge clk);
    chk(txd == 1'b1, "R1 idle line high", int'(txd), 1);

    // single symbol, R4
    pushItem(4'h7, 1'b0, 1'b0);
    waitDrain();
    chk(txd == 1'b1, "R1 high after frame", int'(txd), 1);

    // burst of decimal digits, R4 and R8
    base = startCyc.size();
    for (int i = 0; i < 10; i++) pushItem(4'(i), 1'b0, 1'b0);
    waitDrain();
    checkSpacing(base, 10, "R8 back-to-back spacing");

    // hex letters, R5
    for (int i = 10; i < 16; i++) pushItem(4'(i), 1'b0, 1'b0);
    waitDrain();

    // end marker with non-zero symbol, R6
    pushItem(4'h5, 1'b1, 1'b0);
    pushItem(4'hF, 1'b1, 1'b0);
    waitDrain();

    // abort marker, alone and together with end flag, R7
    pushItem(4'h3, 1'b0, 1'b1);
    pushItem(4'hC, 1'b1, 1'b1);
    waitDrain();

    // entry arriving mid-frame, R9
    base = startCyc.size();
    pushItem(4'hA, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(fifoRead == 1'b0, "R9 no read mid-frame", int'(fifoRead), 0);
    pushItem(4'hB, 1'b0, 1'b0);
    @(negedge clk);
    chk(fifoRead == 1'b0, "R9 no read mid-frame after arrival", int'(fifoRead), 0);
    waitDrain();
    checkSpacing(base, 2, "R9 start follows stop");

    // idle gap then another frame
    repeat (7) @(negedge clk);
    pushItem(4'h0, 1'b0, 1'b0);
    waitDrain();

    chk(expQ.size() == 0, "R3 all frames received", expQ.size(), 0);
    finishRun();
  end

endmodule